// File: doc/BRIEF.md
# 64-bit Halfword Lane and Logic Operation Unit

This block is one execution slice of a multimedia coprocessor datapath. It takes two 64-bit operands and a 4-bit operation select. In the same cycle it returns a 64-bit result.

The supported operations fall into four groups:
- Placing a halfword into a fixed 16-bit lane.
- Pulling out a halfword chosen at run time.
- Whole-register bitwise logic.
- Modulo 64-bit add and subtract, plus an unsigned multiply of the two low 32-bit words.

Any select value outside the supported set raises an illegal-operation flag. In that case the result is held at zero, so that nothing downstream is written with a meaningful value.

The unit is purely combinational. It sits between operand read and result write-back, and its outputs follow its inputs without a register stage.

Top module: `lane_logic_unit`

## Requirements
- R1: Operation codes 0, 1, 2 and 3 are halfword inserts. For code n, the result equals A with bits [16n+15:16n] replaced by B[15:0]. All other bits of A are kept.
- R2: Code 4 is halfword extract. The lane index k is B[1:0], and the result is A[16k+15:16k] zero-extended to 64 bits. B[63:2] has no effect on the result.
- R3: Codes 5, 6, 7 and 8 return A XOR B, NOT(A OR B), A AND B and A OR B respectively, each over all 64 bits.
- R4: Code 9 returns A AND (NOT B). Only the second operand is inverted.
- R5: Code 10 returns (A + B) mod 2^64. A carry out of bit 63 is dropped, with no flag and no saturation.
- R6: Code 11 returns (A - B) mod 2^64. A borrow wraps, with no flag and no saturation.
- R7: Code 12 returns the full 64-bit product of A[31:0] and B[31:0], both taken as unsigned. A[63:32] and B[63:32] have no effect.
- R8: Codes 13, 14 and 15 are unsupported. They drive `illegal_op` high and the result to all zeros, whatever the operands.
- R9: For every code from 0 to 12, `illegal_op` is low. The result reflects the current inputs in the same cycle, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 64 | First operand; the base value for inserts and the source for extract |
| opnd_b | input | 64 | Second operand; the insert data, the extract index, or the second arithmetic/logic input |
| op_sel | input | 4 | Operation code, encoded as listed in R1 to R8 |
| result | output | 64 | Operation result; zero when the code is unsupported |
| illegal_op | output | 1 | High when `op_sel` names no supported operation |

## Verification
The bench uses extract indices whose upper bits of B are all ones. A design that decoded more than two index bits would then return zero or the wrong lane. It also drives the lane-3 insert, where an off-by-one lane position would corrupt bits 63:48 or leave them untouched. The multiply is given all-ones words with junk in the upper halves: a design that let those halves in, or truncated the product, would miss 0xFFFFFFFE00000001. Add and subtract are driven across the wrap point. Unsupported codes are driven with non-zero operands, so that a leaking result or a missing flag shows up at once.

// File: rtl/lane_logic_pkg.sv
package lane_logic_pkg;

    localparam int DATA_W = 64;
    localparam int LANE_W = 16;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_INS0 = 4'd0,
        OP_INS1 = 4'd1,
        OP_INS2 = 4'd2,
        OP_INS3 = 4'd3,
        OP_EXTH = 4'd4,
        OP_XOR  = 4'd5,
        OP_NOR  = 4'd6,
        OP_AND  = 4'd7,
        OP_OR   = 4'd8,
        OP_ANDN = 4'd9,
        OP_ADD  = 4'd10,
        OP_SUB  = 4'd11,
        OP_MULU = 4'd12
    } op_e;

    typedef enum logic [2:0] {
        LG_XOR  = 3'd0,
        LG_NOR  = 3'd1,
        LG_AND  = 3'd2,
        LG_OR   = 3'd3,
        LG_ANDN = 3'd4
    } logic_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              illegal;
    } unit_res_t;

endpackage

// File: rtl/lane_ins_ext.sv
module lane_ins_ext #(
    parameter int DATA_W = 64,
    parameter int LANE_W = 16,
    localparam int LANES = DATA_W / LANE_W,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic [DATA_W-1:0] base_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [IDX_W-1:0]  ins_lane_i,
    output logic [DATA_W-1:0] ins_o,
    output logic [DATA_W-1:0] ext_o
);

    logic [IDX_W-1:0]  ext_lane_d;
    logic [LANE_W-1:0] lane_view_d [LANES];
    logic [LANE_W-1:0] picked_d;

    assign ext_lane_d = src_i[IDX_W-1:0];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_view_d[g] = base_i[g*LANE_W +: LANE_W];
        assign ins_o[g*LANE_W +: LANE_W] =
            (ins_lane_i == IDX_W'(g)) ? src_i[LANE_W-1:0] : base_i[g*LANE_W +: LANE_W];
    end

    always_comb begin
        picked_d = '0;
        for (int i = 0; i < LANES; i++) begin
            if (ext_lane_d == IDX_W'(i)) begin
                picked_d = lane_view_d[i];
            end
        end
    end

    assign ext_o = {{(DATA_W-LANE_W){1'b0}}, picked_d};

endmodule

// File: rtl/wide_logic.sv
module wide_logic
    import lane_logic_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic_e            fn_i,
    output logic [DATA_W-1:0] y_o
);

    always_comb begin
        unique case (fn_i)
            LG_XOR:  y_o = a_i ^ b_i;
            LG_NOR:  y_o = ~(a_i | b_i);
            LG_AND:  y_o = a_i & b_i;
            LG_OR:   y_o = a_i | b_i;
            LG_ANDN: y_o = a_i & ~b_i;
            default: y_o = '0;
        endcase
    end

endmodule

// File: rtl/wide_arith.sv
module wide_arith #(
    parameter int DATA_W = 64,
    localparam int WORD_W = DATA_W / 2
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] sum_o,
    output logic [DATA_W-1:0] diff_o,
    output logic [DATA_W-1:0] prod_o
);

    logic [WORD_W-1:0] a_lo_d;
    logic [WORD_W-1:0] b_lo_d;

    assign a_lo_d = a_i[WORD_W-1:0];
    assign b_lo_d = b_i[WORD_W-1:0];

    assign sum_o  = a_i + b_i;
    assign diff_o = a_i - b_i;
    assign prod_o = DATA_W'(a_lo_d) * DATA_W'(b_lo_d);

endmodule

// File: rtl/lane_logic_unit.sv
module lane_logic_unit
    import lane_logic_pkg::*;
(
    input  logic [63:0] opnd_a,
    input  logic [63:0] opnd_b,
    input  logic [3:0]  op_sel,
    output logic [63:0] result,
    output logic        illegal_op
);

    localparam int LANES = DATA_W / LANE_W;
    localparam int IDX_W = $clog2(LANES);

    logic [DATA_W-1:0] ins_d;
    logic [DATA_W-1:0] ext_d;
    logic [DATA_W-1:0] lgc_d;
    logic [DATA_W-1:0] sum_d;
    logic [DATA_W-1:0] diff_d;
    logic [DATA_W-1:0] prod_d;
    logic_e            lg_fn_d;
    unit_res_t         res_d;

    lane_ins_ext #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) u_lane (
        .base_i     (opnd_a),
        .src_i      (opnd_b),
        .ins_lane_i (op_sel[IDX_W-1:0]),
        .ins_o      (ins_d),
        .ext_o      (ext_d)
    );

    always_comb begin
        unique case (op_sel)
            OP_XOR:  lg_fn_d = LG_XOR;
            OP_NOR:  lg_fn_d = LG_NOR;
            OP_AND:  lg_fn_d = LG_AND;
            OP_OR:   lg_fn_d = LG_OR;
            default: lg_fn_d = LG_ANDN;
        endcase
    end

    wide_logic #(
        .DATA_W (DATA_W)
    ) u_logic (
        .a_i  (opnd_a),
        .b_i  (opnd_b),
        .fn_i (lg_fn_d),
        .y_o  (lgc_d)
    );

    wide_arith #(
        .DATA_W (DATA_W)
    ) u_arith (
        .a_i    (opnd_a),
        .b_i    (opnd_b),
        .sum_o  (sum_d),
        .diff_o (diff_d),
        .prod_o (prod_d)
    );

    always_comb begin
        res_d = '{data: '0, illegal: 1'b0};
        unique case (op_sel)
            OP_INS0, OP_INS1, OP_INS2, OP_INS3: res_d.data = ins_d;
            OP_EXTH:                            res_d.data = ext_d;
            OP_XOR, OP_NOR, OP_AND, OP_OR,
            OP_ANDN:                            res_d.data = lgc_d;
            OP_ADD:                             res_d.data = sum_d;
            OP_SUB:                             res_d.data = diff_d;
            OP_MULU:                            res_d.data = prod_d;
            default: begin
                res_d.data    = '0;
                res_d.illegal = 1'b1;
            end
        endcase
    end

    assign result     = res_d.data;
    assign illegal_op = res_d.illegal;

endmodule

// File: rtl/lane_logic_unit_chk.sv
module lane_logic_unit_chk (
    input logic [63:0] opnd_a,
    input logic [63:0] opnd_b,
    input logic [3:0]  op_sel,
    input logic [63:0] result,
    input logic        illegal_op
);

    always_comb begin
        if (op_sel >= 4'd13) begin
            a_r8_illegal_zero: assert (illegal_op && result == 64'd0);
        end else begin
            a_r9_legal_flag_low: assert (!illegal_op);
        end
        if (op_sel <= 4'd3) begin
            a_r1_other_lanes_kept: assert (((result ^ opnd_a) & ~(64'hFFFF << (16 * op_sel))) == 64'd0);
            a_r1_lane_written: assert (((result >> (16 * op_sel)) & 64'hFFFF) == {48'd0, opnd_b[15:0]});
        end
        if (op_sel == 4'd4) begin
            a_r2_zero_extended: assert (result[63:16] == 48'd0);
        end
        if (op_sel == 4'd9) begin
            a_r4_andn_clears_b: assert ((result & opnd_b) == 64'd0);
        end
        if (op_sel == 4'd10) begin
            a_r5_add_inverse: assert (result - opnd_b == opnd_a);
        end
        if (op_sel == 4'd11) begin
            a_r6_sub_inverse: assert (result + opnd_b == opnd_a);
        end
    end

endmodule

bind lane_logic_unit lane_logic_unit_chk chk_i (
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .op_sel     (op_sel),
    .result     (result),
    .illegal_op (illegal_op)
);

// File: tb/lane_logic_unit_tb_top.sv
module lane_logic_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 600;

    logic        clk;
    logic [63:0] opnd_a;
    logic [63:0] opnd_b;
    logic [3:0]  op_sel;
    logic [63:0] result;
    logic        illegal_op;

    int n_checks;
    int n_errors;
    bit done;

    lane_logic_unit dut_i (
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .op_sel     (op_sel),
        .result     (result),
        .illegal_op (illegal_op)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] model(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b);
        logic [63:0] r;
        logic [63:0] k;
        r = a;
        case (op)
            4'd0: r[15:0]  = b[15:0];            // R1
            4'd1: r[31:16] = b[15:0];
            4'd2: r[47:32] = b[15:0];
            4'd3: r[63:48] = b[15:0];
            4'd4: begin                          // R2
                k = {62'd0, b[1:0]};
                r = (a >> (k * 16)) & 64'h0000_0000_0000_FFFF;
            end
            4'd5: r = a ^ b;                     // R3
            4'd6: r = ~(a | b);
            4'd7: r = a & b;
            4'd8: r = a | b;
            4'd9: r = a & ~b;                    // R4
            4'd10: r = a + b;                    // R5
            4'd11: r = a - b;                    // R6
            4'd12: r = {32'd0, a[31:0]} * {32'd0, b[31:0]}; // R7
            default: r = 64'd0;                  // R8
        endcase
        return r;
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        if (op <= 4'd3) return "R1";
        if (op == 4'd4) return "R2";
        if (op <= 4'd8) return "R3";
        if (op == 4'd9) return "R4";
        if (op == 4'd10) return "R5";
        if (op == 4'd11) return "R6";
        if (op == 4'd12) return "R7";
        return "R8";
    endfunction

    task automatic apply_check(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b);
        logic [63:0] exp_r;
        logic        exp_f;
        @(negedge clk);
        op_sel = op;
        opnd_a = a;
        opnd_b = b;
        #1;
        exp_r = model(op, a, b);
        exp_f = (op >= 4'd13);
        n_checks++;
        if (result !== exp_r) begin
            n_errors++;
            $display("FAIL %s op=%0d result=%h expected=%h", tag_of(op), op, result, exp_r);
        end
        n_checks++;
        if (illegal_op !== exp_f) begin
            n_errors++;
            $display("FAIL %s illegal_op op=%0d actual=%b expected=%b",
                     exp_f ? "R8" : "R9", op, illegal_op, exp_f);
        end
    endtask

    initial begin
        n_checks = 0;
        n_errors = 0;
        done     = 1'b0;
        op_sel   = 4'd0;
        opnd_a   = 64'd0;
        opnd_b   = 64'd0;
        void'($urandom(32'h5EED_1234));

        // R9: idle state with zero inputs gives a legal zero insert
        apply_check(4'd0, 64'd0, 64'd0);

        // R1: insert into each lane, including the top lane
        for (int n = 0; n < 4; n++) begin
            apply_check(4'(n), 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_A5C3);
        end
        // R2: extract with junk in upper bits of B, every index
        for (int n = 0; n < 4; n++) begin
            apply_check(4'd4, 64'hDEAD_BEEF_CAFE_F00D, {62'h3FFF_FFFF_FFFF_FFFF, 2'(n)});
        end
        // R3, R4: logic on complementary patterns
        for (int n = 5; n <= 9; n++) begin
            apply_check(4'(n), 64'hF0F0_FF00_AAAA_0000, 64'h0FF0_F0F0_5555_FFFF);
        end
        // R5: add wrap across 2^64
        apply_check(4'd10, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
        apply_check(4'd10, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000);
        // R6: subtract borrow wrap
        apply_check(4'd11, 64'd0, 64'd1);
        apply_check(4'd11, 64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
        // R7: max words with junk high halves
        apply_check(4'd12, 64'h1234_5678_FFFF_FFFF, 64'h9ABC_DEF0_FFFF_FFFF);
        apply_check(4'd12, 64'hFFFF_FFFF_0000_0003, 64'hFFFF_FFFF_0000_0005);
        // R8: unsupported codes with non-zero operands
        for (int n = 13; n < 16; n++) begin
            apply_check(4'(n), 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0);
        end

        // Random mix over all codes
        for (int i = 0; i < N_RAND; i++) begin
            apply_check(4'($urandom_range(0, 15)), {$urandom, $urandom}, {$urandom, $urandom});
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule